// File: doc/BRIEF.md
# Periodic Stream Stimulus Source

This block is a free-running test source for a 64-bit streaming data path. It drives the data and valid lines of an AXI4-Stream master with a fixed schedule that repeats every 128 clock cycles. Each frame holds two ten-beat valid bursts: the first carries a fixed non-zero pattern word, and the second carries all-zero words. Between the bursts the source is idle, with valid low and data zero. The sink's ready line is not honoured. The schedule advances every cycle, so the sink sees the same timing in every frame. That steady timing is what makes the source useful for measuring the latency of a downstream streaming inference core.

Alongside the stream, the block reports its position in the frame. It also gives a one-cycle strobe on the first beat of each burst and a bit that tells the two bursts apart. A latency monitor can then timestamp each burst without decoding the data. All outputs come from registers. Reset is synchronous and active high.

Top module: `stream_stim`

## Requirements
- R1: `frame_pos` advances by one on every clock out of reset, counting from 0 to 127. After 127 it returns to 0.
- R2: At frame positions 0 to 19, `tvalid` is low and `tdata` is zero.
- R3: At frame positions 20 to 29, `tvalid` is high and `tdata` is 64'hABCDABCDEFABCDEF.
- R4: At frame positions 30 to 83, `tvalid` is low and `tdata` is zero.
- R5: At frame positions 84 to 93, `tvalid` is high and `tdata` is zero.
- R6: At frame positions 94 to 127, `tvalid` is low and `tdata` is zero.
- R7: `tready` has no effect. With `tready` held low, the schedule, data and strobes are exactly those of R1 to R6, R9 and R10.
- R8: While `rst` is high at a clock edge, the next cycle shows `frame_pos` 0, `tvalid` low, `tdata` zero, `burst_start` low and `burst_id` low. In the first cycle after `rst` falls, the outputs still show these position-0 idle values.
- R9: `burst_start` is high for exactly one cycle at frame positions 20 and 84, and low at every other position.
- R10: `burst_id` is 1 at frame positions 84 to 93 and 0 at every other position, so it reads 0 on the first burst and 1 on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tready | input | 1 | Sink ready; ignored |
| tdata | output | 64 | Stream data |
| tvalid | output | 1 | Stream valid |
| frame_pos | output | 7 | Current position in the frame |
| burst_start | output | 1 | Pulse on the first beat of each burst |
| burst_id | output | 1 | 0 for the pattern burst, 1 for the zero burst |

## Verification
The bench builds the block with its default parameters: a 128-cycle frame, bursts at 20 and 84, and the default pattern word. It runs more than three full frames, so every window edge and the wrap from 127 to 0 are seen several times. It also applies a reset in the middle of a frame and then runs for more than another frame, which covers restart from position 0 mid-schedule. During one whole frame `tready` is held low; elsewhere it toggles at random, so any dependence on ready would show up as a schedule shift.

// File: rtl/stream_stim.sv
module stream_stim #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned FRAME_LEN = 128,
  parameter int unsigned A_START   = 20,
  parameter int unsigned A_LEN     = 10,
  parameter int unsigned B_START   = 84,
  parameter int unsigned B_LEN     = 10,
  parameter logic [DATA_W-1:0] PATTERN = 64'hABCDABCDEFABCDEF,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tready,
  output logic [DATA_W-1:0] tdata,
  output logic              tvalid,
  output logic [CNT_W-1:0]  frame_pos,
  output logic              burst_start,
  output logic              burst_id
);
  localparam int unsigned A_END = A_START + A_LEN;
  localparam int unsigned B_END = B_START + B_LEN;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] nxt;
  logic [31:0]      nx32, cur32;
  logic             in_a, in_b;

  assign nxt   = (frame_pos == LAST) ? '0 : frame_pos + 1'b1;
  assign nx32  = 32'(nxt);
  assign cur32 = 32'(frame_pos);
  assign in_a  = (nx32 >= A_START) && (nx32 < A_END);
  assign in_b  = (nx32 >= B_START) && (nx32 < B_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_pos   <= '0;
      tvalid      <= 1'b0;
      tdata       <= '0;
      burst_start <= 1'b0;
      burst_id    <= 1'b0;
    end else begin
      frame_pos   <= nxt;
      tvalid      <= in_a | in_b;
      tdata       <= in_a ? PATTERN : '0;
      burst_start <= (nx32 == A_START) || (nx32 == B_START);
      burst_id    <= in_b;
    end
  end

  // R1
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> frame_pos == (($past(frame_pos) == LAST) ? '0 : $past(frame_pos) + 1'b1));

  // R2 R3 R4 R5 R6
  valid_window_chk: assert property (@(posedge clk) disable iff (rst)
    tvalid == (((cur32 >= A_START) && (cur32 < A_END)) || ((cur32 >= B_START) && (cur32 < B_END))));

  // R3
  data_only_in_a_chk: assert property (@(posedge clk) disable iff (rst)
    (tdata != '0) |-> (tvalid && !burst_id));

  // R7
  no_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
    (tvalid && !tready) |=> frame_pos != $past(frame_pos));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (frame_pos == '0 && !tvalid && tdata == '0 && !burst_start && !burst_id));

  // R9
  start_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tvalid) |-> burst_start);

  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    burst_start |=> !burst_start);

  // R10
  id_implies_valid_chk: assert property (@(posedge clk) disable iff (rst)
    burst_id |-> tvalid);
endmodule

// File: tb/sim_stream_stim.sv
`timescale 1ns/1ps
module sim_stream_stim;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tready = 1'b0;
  logic [63:0] tdata;
  logic        tvalid;
  logic [6:0]  frame_pos;
  logic        burst_start;
  logic        burst_id;

  always #4 clk = ~clk;

  stream_stim u0 (
    .clk(clk), .rst(rst), .tready(tready), .tdata(tdata), .tvalid(tvalid),
    .frame_pos(frame_pos), .burst_start(burst_start), .burst_id(burst_id)
  );

  typedef struct {
    int          pos;
    logic        valid;
    logic [63:0] data;
    logic        start;
    logic        id;
    bit          in_rst;
    bit          hold_lo;
  } item_t;

  item_t q[$];
  int applied = 0;
  int errors  = 0;
  int m       = 0;
  bit hold_phase = 0;
  bit done = 0;

  function automatic string win_tag(int p);
    if (p < 20) return "R2";
    if (p < 30) return "R3";
    if (p < 84) return "R4";
    if (p < 94) return "R5";
    return "R6";
  endfunction

  function automatic item_t model(int p, bit r, bit h);
    item_t e;
    e.pos     = p;
    e.valid   = ((p >= 20) && (p < 30)) || ((p >= 84) && (p < 94));
    e.data    = ((p >= 20) && (p < 30)) ? 64'hABCDABCDEFABCDEF : 64'h0;
    e.start   = (p == 20) || (p == 84);
    e.id      = (p >= 84) && (p < 94);
    e.in_rst  = r;
    e.hold_lo = h;
    return e;
  endfunction

  task automatic fail(string tag, string what, logic [63:0] act, logic [63:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic tick(input bit r);
    bit sampled;
    @(posedge clk);
    sampled = rst;
    if (sampled) m = 0;
    else m = (m + 1) % 128;
    #1;
    rst = r;
    tready = hold_phase ? 1'b0 : 1'($urandom_range(0, 1));
    q.push_back(model(m, sampled, hold_phase));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      string wt;
      e = q.pop_front();
      applied++;
      wt = e.in_rst ? "R8" : (e.hold_lo ? "R7" : win_tag(e.pos));
      if (32'(frame_pos) != e.pos)
        fail(e.in_rst ? "R8" : (e.hold_lo ? "R7" : "R1"), "frame_pos", 64'(frame_pos), 64'(e.pos));
      else if (tvalid !== e.valid)
        fail(wt, "tvalid", 64'(tvalid), 64'(e.valid));
      else if (tdata !== e.data)
        fail(wt, "tdata", tdata, e.data);
      else if (burst_start !== e.start)
        fail(e.in_rst ? "R8" : (e.hold_lo ? "R7" : "R9"), "burst_start", 64'(burst_start), 64'(e.start));
      else if (burst_id !== e.id)
        fail(e.in_rst ? "R8" : (e.hold_lo ? "R7" : "R10"), "burst_id", 64'(burst_id), 64'(e.id));
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset held, then released
    for (int i = 0; i < 3; i++) tick(1'b1);
    tick(1'b0);
    // R1-R6, R9, R10 over several frames with random ready
    for (int i = 0; i < 300; i++) tick(1'b0);
    // R7: ready held low for a whole frame
    hold_phase = 1;
    for (int i = 0; i < 130; i++) tick(1'b0);
    hold_phase = 0;
    // R8: reset in mid-frame
    tick(1'b1);
    tick(1'b1);
    tick(1'b0);
    for (int i = 0; i < 140; i++) tick(1'b0);
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule